// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block is the host side of a single-bit SPI link to a serial NOR flash, running in clock mode 0. A client gives it one operation at a time over a valid/ready command port. The operations are read, fast read, sector erase, block erase, chip erase, byte program, status read, identification read and status write. The sequencer then builds every frame the operation needs on the wire, one byte at a time, most significant bit first.

Operations that change the array are preceded by their own write-enable frame. A status write is preceded by its own enable frame. After a program or erase, the sequencer keeps issuing status-read frames until the flash reports that it is idle, and reports completion only then. Bytes read from the flash are delivered on a valid/ready stream. When the stream is stalled, the serial clock simply pauses. Two clock-divider settings are provided: a slower one used only for plain reads, and a faster one for every other frame.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset spi_cs_n is 1, spi_sck is 0, cmd_ready is 1, rd_valid is 0 and done is 0.
- R2: The link runs in SPI mode 0, with spi_sck low whenever spi_cs_n is high. spi_mosi changes only while spi_sck is low. Each byte goes out most significant bit first, and spi_miso is sampled on the rising edge of spi_sck.
- R3: The frame layouts are as follows, with addresses sent as three bytes, most significant byte first:
  - cmd_op 0 (read) sends 03h and the address.
  - cmd_op 1 (fast read) sends 0Bh, the address and one 00h dummy byte.
  - cmd_op 2 (sector erase) sends 20h and the address.
  - cmd_op 3 (block erase) sends D8h and the address.
  - cmd_op 4 (chip erase) sends 60h alone.
  - cmd_op 5 (byte program) sends 02h, the address and cmd_wdata.
- R4: Operations 2 to 5 are preceded by a separate frame holding only 06h, with spi_cs_n high between that frame and the main frame.
- R5: A status write (cmd_op 8) is sent as a frame holding only 50h. The very next frame is 01h followed by cmd_wdata. No status poll follows it.
- R6: Data capture works per operation as follows, and spi_cs_n stays low until the last requested byte has been shifted in:
  - A read or fast read captures cmd_len bytes.
  - A status read (cmd_op 6) sends 05h and captures 1 byte.
  - An identification read (cmd_op 7) sends 9Fh and captures 3 bytes.
- R7: A captured byte is held on rd_data with rd_valid high until rd_ready is high. No byte is lost or repeated while the stream is stalled.
- R8: In a read frame (cmd_op 0), each spi_sck high and low phase lasts DIV_SLOW clocks. In every other frame, each phase lasts DIV_FAST clocks.
- R9: After a program or erase, the block sends repeated frames of 05h plus one captured byte. It pulses done with err 0 after the first poll whose bit 0 is 0.
- R10: If POLL_LIMIT polls in a row all return bit 0 set, done pulses with err 1 and no further frame is sent.
- R11: spi_cs_n stays high for at least CS_GAP clock cycles between any two frames.
- R12: cmd_ready is low from the cycle after a command is accepted until done. Any cmd_valid seen in that time is ignored.
- R13: A cmd_op value of 9 to 15 sends no frame and ends with a done pulse with err 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command taken when both high |
| cmd_op | input | 4 | Operation code, see R3 to R6 and R13 |
| cmd_addr | input | 24 | Flash byte address |
| cmd_wdata | input | 8 | Program data or new status value |
| cmd_len | input | LEN_W | Byte count for read and fast read |
| rd_data | output | 8 | Captured byte |
| rd_valid | output | 1 | rd_data holds a byte |
| rd_ready | input | 1 | Consumer takes the byte |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error flag, valid while done is high |
| spi_sck | output | 1 | Serial clock to the flash |
| spi_cs_n | output | 1 | Active-low chip enable |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The hardest states to reach are the status-poll loop and its timeout, because the flash decides how long it stays busy. The bench therefore contains a behavioural flash model with a settable count of busy status replies. That count is set to two for a program, zero for an erase, and well beyond POLL_LIMIT for a chip erase. This drives the loop to a clean exit and to the timeout exit. A fast read also runs against a stream consumer that stalls every other cycle. This holds the sequencer in its wait state with the serial clock paused in the middle of a frame.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [3:0] {
    OP_READ   = 4'd0,
    OP_FREAD  = 4'd1,
    OP_SERASE = 4'd2,
    OP_BERASE = 4'd3,
    OP_CERASE = 4'd4,
    OP_PROG   = 4'd5,
    OP_RSTAT  = 4'd6,
    OP_RID    = 4'd7,
    OP_WSTAT  = 4'd8
  } op_e;

  typedef enum logic [1:0] {
    FR_PRE  = 2'd0,
    FR_MAIN = 2'd1,
    FR_POLL = 2'd2
  } frame_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_GAP  = 3'd1,
    S_TX   = 3'd2,
    S_RX   = 3'd3,
    S_HOLD = 3'd4
  } state_e;

  localparam logic [7:0] CODE_WEN   = 8'h06;
  localparam logic [7:0] CODE_SWEN  = 8'h50;
  localparam logic [7:0] CODE_STAT  = 8'h05;
  localparam logic [7:0] CODE_DUMMY = 8'h00;

  typedef struct packed {
    logic       valid;
    logic [7:0] opcode;
    logic       need_pre;
    logic [7:0] pre_code;
    logic       has_addr;
    logic       has_extra;
    logic       extra_dummy;
    logic [1:0] rx_fixed;
    logic       rx_use_len;
    logic       need_poll;
    logic       slow;
  } dec_t;

endpackage

// File: rtl/fsq_decode.sv
module fsq_decode
  import flash_seq_pkg::*;
(
  input  logic [3:0] op,
  output dec_t       dec
);

  always_comb begin
    dec       = '0;
    dec.valid = 1'b1;
    case (op)
      OP_READ: begin
        dec.opcode = 8'h03; dec.has_addr = 1'b1;
        dec.rx_use_len = 1'b1; dec.slow = 1'b1;
      end
      OP_FREAD: begin
        dec.opcode = 8'h0B; dec.has_addr = 1'b1; dec.has_extra = 1'b1;
        dec.extra_dummy = 1'b1; dec.rx_use_len = 1'b1;
      end
      OP_SERASE: begin
        dec.opcode = 8'h20; dec.has_addr = 1'b1;
        dec.need_pre = 1'b1; dec.pre_code = CODE_WEN; dec.need_poll = 1'b1;
      end
      OP_BERASE: begin
        dec.opcode = 8'hD8; dec.has_addr = 1'b1;
        dec.need_pre = 1'b1; dec.pre_code = CODE_WEN; dec.need_poll = 1'b1;
      end
      OP_CERASE: begin
        dec.opcode = 8'h60;
        dec.need_pre = 1'b1; dec.pre_code = CODE_WEN; dec.need_poll = 1'b1;
      end
      OP_PROG: begin
        dec.opcode = 8'h02; dec.has_addr = 1'b1; dec.has_extra = 1'b1;
        dec.need_pre = 1'b1; dec.pre_code = CODE_WEN; dec.need_poll = 1'b1;
      end
      OP_RSTAT: begin
        dec.opcode = CODE_STAT; dec.rx_fixed = 2'd1;
      end
      OP_RID: begin
        dec.opcode = 8'h9F; dec.rx_fixed = 2'd3;
      end
      OP_WSTAT: begin
        dec.opcode = 8'h01; dec.has_extra = 1'b1;
        dec.need_pre = 1'b1; dec.pre_code = CODE_SWEN;
      end
      default: dec.valid = 1'b0;
    endcase
  end

endmodule

// File: rtl/fsq_shifter.sv
module fsq_shifter #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [7:0]       tx_byte,
  input  logic [DIV_W-1:0] half,
  input  logic             miso,
  output logic             busy,
  output logic             sck,
  output logic             mosi,
  output logic [7:0]       rx_byte,
  output logic             byte_done
);

  logic [7:0]       sh_q;
  logic [2:0]       bit_q;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] half_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      sck       <= 1'b0;
      mosi      <= 1'b0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
      sh_q      <= '0;
      bit_q     <= '0;
      cnt_q     <= '0;
      half_q    <= DIV_W'(1);
    end else begin
      byte_done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          sh_q   <= tx_byte;
          mosi   <= tx_byte[7];
          bit_q  <= '0;
          cnt_q  <= '0;
          half_q <= half;
        end
      end else if (cnt_q == half_q - DIV_W'(1)) begin
        cnt_q <= '0;
        if (!sck) begin
          sck     <= 1'b1;
          rx_byte <= {rx_byte[6:0], miso};
        end else begin
          sck <= 1'b0;
          if (bit_q == 3'd7) begin
            busy      <= 1'b0;
            byte_done <= 1'b1;
          end else begin
            bit_q <= bit_q + 3'd1;
            mosi  <= sh_q[6];
            sh_q  <= {sh_q[6:0], 1'b0};
          end
        end
      end else begin
        cnt_q <= cnt_q + DIV_W'(1);
      end
    end
  end

  // R2: serial clock rests low outside a byte
  assert_sck_rest_low_R2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sck);

  // R2: data line holds while the clock is high
  assert_mosi_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (sck && $past(sck)) |-> $stable(mosi));

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int DIV_SLOW   = 4,
  parameter int DIV_FAST   = 2,
  parameter int CS_GAP     = 4,
  parameter int POLL_LIMIT = 1000,
  parameter int LEN_W      = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [3:0]       cmd_op,
  input  logic [23:0]      cmd_addr,
  input  logic [7:0]       cmd_wdata,
  input  logic [LEN_W-1:0] cmd_len,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic             done,
  output logic             err,
  output logic             spi_sck,
  output logic             spi_cs_n,
  output logic             spi_mosi,
  input  logic             spi_miso
);

  localparam int GAP_W  = $clog2(CS_GAP + 1);
  localparam int POLL_W = $clog2(POLL_LIMIT + 1);

  state_e           state_q;
  frame_e           frame_q;
  logic             fin_q;
  logic [3:0]       op_q;
  logic [23:0]      addr_q;
  logic [7:0]       wdata_q;
  logic [LEN_W-1:0] len_q;
  logic [2:0]       idx_q;
  logic [LEN_W-1:0] rx_left_q;
  logic [POLL_W-1:0] poll_q;
  logic [GAP_W-1:0] gap_q;
  logic             sh_start_q;
  logic [7:0]       sh_tx_q;

  logic             sh_busy;
  logic [7:0]       sh_rx;
  logic             sh_done;

  dec_t             dec;
  logic [3:0]       dec_op;
  logic [7:0]       arr [8];
  logic [2:0]       ntx;
  logic [LEN_W-1:0] nrx;
  logic [DIV_W-1:0] half;
  logic [7:0]       extra;
  logic             last_tx;
  logic             end_now;

  assign dec_op = (state_q == S_IDLE) ? cmd_op : op_q;

  fsq_decode u_dec (
    .op  (dec_op),
    .dec (dec)
  );

  fsq_shifter #(.DIV_W(DIV_W)) u_sh (
    .clk       (clk),
    .rst       (rst),
    .start     (sh_start_q),
    .tx_byte   (sh_tx_q),
    .half      (half),
    .miso      (spi_miso),
    .busy      (sh_busy),
    .sck       (spi_sck),
    .mosi      (spi_mosi),
    .rx_byte   (sh_rx),
    .byte_done (sh_done)
  );

  // Frame contents selected by frame kind
  always_comb begin
    extra = dec.extra_dummy ? CODE_DUMMY : wdata_q;
    for (int i = 0; i < 8; i++) arr[i] = 8'h00;
    ntx  = 3'd1;
    nrx  = '0;
    half = DIV_W'(DIV_FAST);
    case (frame_q)
      FR_PRE: arr[0] = dec.pre_code;
      FR_POLL: begin
        arr[0] = CODE_STAT;
        nrx    = LEN_W'(1);
      end
      default: begin
        arr[0] = dec.opcode;
        if (dec.has_addr) begin
          arr[1] = addr_q[23:16];
          arr[2] = addr_q[15:8];
          arr[3] = addr_q[7:0];
          arr[4] = extra;
        end else begin
          arr[1] = extra;
        end
        ntx = 3'd1 + (dec.has_addr ? 3'd3 : 3'd0) + (dec.has_extra ? 3'd1 : 3'd0);
        nrx = dec.rx_use_len ? len_q : LEN_W'(dec.rx_fixed);
        if (dec.slow) half = DIV_W'(DIV_SLOW);
      end
    endcase
  end

  assign last_tx = (idx_q + 3'd1) >= ntx;
  assign end_now = (state_q == S_TX && sh_done && last_tx && nrx == '0) ||
                   (state_q == S_RX && sh_done && frame_q == FR_POLL) ||
                   (state_q == S_HOLD && rd_ready && rx_left_q == '0);

  assign cmd_ready = (state_q == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      frame_q    <= FR_MAIN;
      fin_q      <= 1'b0;
      err        <= 1'b0;
      done       <= 1'b0;
      op_q       <= '0;
      addr_q     <= '0;
      wdata_q    <= '0;
      len_q      <= '0;
      idx_q      <= '0;
      rx_left_q  <= '0;
      poll_q     <= '0;
      gap_q      <= '0;
      spi_cs_n   <= 1'b1;
      sh_start_q <= 1'b0;
      sh_tx_q    <= '0;
      rd_data    <= '0;
      rd_valid   <= 1'b0;
    end else begin
      sh_start_q <= 1'b0;
      done       <= 1'b0;
      case (state_q)
        S_IDLE: if (cmd_valid) begin
          op_q    <= cmd_op;
          addr_q  <= cmd_addr;
          wdata_q <= cmd_wdata;
          len_q   <= cmd_len;
          poll_q  <= '0;
          gap_q   <= '0;
          fin_q   <= !dec.valid;
          err     <= !dec.valid;
          frame_q <= dec.need_pre ? FR_PRE : FR_MAIN;
          state_q <= S_GAP;
        end
        S_GAP: begin
          if (gap_q >= GAP_W'(CS_GAP - 1)) begin
            if (fin_q) begin
              done    <= 1'b1;
              state_q <= S_IDLE;
            end else begin
              spi_cs_n   <= 1'b0;
              idx_q      <= '0;
              rx_left_q  <= nrx;
              sh_start_q <= 1'b1;
              sh_tx_q    <= arr[0];
              state_q    <= S_TX;
            end
          end else begin
            gap_q <= gap_q + GAP_W'(1);
          end
        end
        S_TX: if (sh_done) begin
          if (!last_tx) begin
            idx_q      <= idx_q + 3'd1;
            sh_start_q <= 1'b1;
            sh_tx_q    <= arr[idx_q + 3'd1];
          end else if (nrx != '0) begin
            sh_start_q <= 1'b1;
            sh_tx_q    <= CODE_DUMMY;
            state_q    <= S_RX;
          end
        end
        S_RX: if (sh_done) begin
          rx_left_q <= rx_left_q - LEN_W'(1);
          if (frame_q != FR_POLL) begin
            rd_data  <= sh_rx;
            rd_valid <= 1'b1;
            state_q  <= S_HOLD;
          end
        end
        S_HOLD: if (rd_ready) begin
          rd_valid <= 1'b0;
          if (rx_left_q != '0) begin
            sh_start_q <= 1'b1;
            sh_tx_q    <= CODE_DUMMY;
            state_q    <= S_RX;
          end
        end
        default: state_q <= S_IDLE;
      endcase

      if (end_now) begin
        spi_cs_n <= 1'b1;
        gap_q    <= '0;
        state_q  <= S_GAP;
        case (frame_q)
          FR_PRE: frame_q <= FR_MAIN;
          FR_MAIN: begin
            if (dec.need_poll) frame_q <= FR_POLL;
            else fin_q <= 1'b1;
          end
          default: begin
            if (!sh_rx[0]) begin
              fin_q <= 1'b1;
            end else if (poll_q == POLL_W'(POLL_LIMIT - 1)) begin
              fin_q <= 1'b1;
              err   <= 1'b1;
            end else begin
              poll_q <= poll_q + POLL_W'(1);
            end
          end
        endcase
      end
    end
  end

  // Independent run-length of chip-enable high time
  logic [GAP_W-1:0] hi_run_q;
  always_ff @(posedge clk) begin
    if (rst) hi_run_q <= '0;
    else if (!spi_cs_n) hi_run_q <= '0;
    else if (hi_run_q < GAP_W'(CS_GAP)) hi_run_q <= hi_run_q + GAP_W'(1);
  end

  assert_gap_met_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_cs_n) |-> hi_run_q >= GAP_W'(CS_GAP));

  assert_sck_low_deselected_R2: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sck);

  assert_take_drops_ready_R12: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  assert_stream_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_poll_bound_R10: assert property (@(posedge clk) disable iff (rst)
    poll_q < POLL_W'(POLL_LIMIT));

  assert_no_byte_idle_R1: assert property (@(posedge clk) disable iff (rst)
    (cmd_ready && !cmd_valid) |=> !sh_busy);

endmodule

// File: tb/flash_cmd_seq_test.sv
module flash_cmd_seq_test;

  localparam int CS_GAP = 4;
  localparam int POLL_LIMIT = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [3:0] cmd_op = '0;
  logic [23:0] cmd_addr = '0;
  logic [7:0] cmd_wdata = '0;
  logic [7:0] cmd_len = '0;
  logic [7:0] rd_data;
  logic rd_valid;
  logic rd_ready = 1'b0;
  logic done, err;
  logic spi_sck, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;

  always #5 clk = ~clk;

  flash_cmd_seq #(.DIV_SLOW(4), .DIV_FAST(2), .CS_GAP(CS_GAP),
                  .POLL_LIMIT(POLL_LIMIT), .LEN_W(8)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_len(cmd_len),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .done(done), .err(err), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  int checks = 0;
  int fails  = 0;

  // Flash model bookkeeping
  int nfr = 0;
  int cur = 0;
  int bitn = 0;
  logic [7:0] sh = '0;
  logic [7:0] fb [16][8];
  int flen [16];
  int fgap [16];
  int fhi  [16];
  int busy_left = 0;
  logic in_frame = 1'b0;

  // Stream and completion capture
  logic [7:0] rxb [16];
  int rxn = 0;
  logic bp = 1'b0;
  int bp_cnt = 0;
  logic done_seen = 1'b0;
  logic err_seen = 1'b0;
  int gapcnt = 0;
  int hicnt = 0;
  logic prev_cs = 1'b1;
  int cyc = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] resp(input int k);
    logic [7:0] op;
    op = fb[cur][0];
    if (k == 0) return 8'h00;
    case (op)
      8'h03: if (k >= 4) return fb[cur][3] + 8'(k - 4);
      8'h0B: if (k >= 5) return fb[cur][3] + 8'(k - 5);
      8'h05: return (busy_left > 0) ? 8'h1D : 8'h1C;
      8'h9F: begin
        if (k == 1) return 8'hEF;
        if (k == 2) return 8'h40;
        if (k == 3) return 8'h17;
      end
      default: ;
    endcase
    return 8'h00;
  endfunction

  always @(negedge spi_cs_n) begin
    if (!rst) begin
      cur = nfr;
      bitn = 0;
      if (cur < 16) flen[cur] = 0;
      in_frame = 1'b1;
      spi_miso = 1'b0;
    end
  end

  always @(posedge spi_cs_n) begin
    if (in_frame) begin
      in_frame = 1'b0;
      if (cur < 16 && fb[cur][0] == 8'h05 && busy_left > 0) busy_left--;
      nfr++;
    end
  end

  always @(posedge spi_sck) begin
    if (spi_cs_n === 1'b0 && cur < 16) begin
      sh = {sh[6:0], spi_mosi};
      bitn++;
      if (bitn % 8 == 0) begin
        if (bitn / 8 - 1 < 8) fb[cur][bitn/8-1] = sh;
        flen[cur]++;
      end
    end
  end

  always @(negedge spi_sck) begin
    if (spi_cs_n === 1'b0 && cur < 16) begin
      logic [7:0] b;
      b = resp(bitn / 8);
      spi_miso = b[7 - (bitn % 8)];
    end
  end

  always @(negedge clk) begin
    cyc++;
    // consumer ready pattern, then the transfer it makes at the next edge
    if (bp) begin
      bp_cnt++;
      rd_ready = (bp_cnt % 2 == 0);
    end else begin
      rd_ready = 1'b1;
    end
    if (rd_valid && rd_ready && rxn < 16) begin
      rxb[rxn] = rd_data;
      rxn++;
    end
    if (done) begin
      done_seen = 1'b1;
      err_seen  = err;
    end
    if (prev_cs && !spi_cs_n) begin
      if (nfr < 16) fgap[nfr] = gapcnt;
      gapcnt = 0;
    end
    if (spi_cs_n) gapcnt++;
    if (!spi_cs_n && spi_sck) hicnt++;
    else if (hicnt != 0) begin
      if (nfr < 16) fhi[nfr] = hicnt;
      hicnt = 0;
    end
    prev_cs = spi_cs_n;
    if (cyc > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic issue(input logic [3:0] op, input logic [23:0] a,
                       input logic [7:0] d, input logic [7:0] n);
    nfr = 0;
    rxn = 0;
    done_seen = 1'b0;
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_len = n;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000 && !done_seen; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run(input logic [3:0] op, input logic [23:0] a,
                     input logic [7:0] d, input logic [7:0] n);
    issue(op, a, d, n);
    wait_done();
  endtask

  task automatic t_reset();
    chk("R1 cs_n", int'(spi_cs_n), 1);
    chk("R1 sck", int'(spi_sck), 0);
    chk("R1 cmd_ready", int'(cmd_ready), 1);
    chk("R1 rd_valid", int'(rd_valid), 0);
    chk("R1 done", int'(done), 0);
  endtask

  task automatic t_read();
    run(4'd0, 24'h123456, 8'h00, 8'd4);
    chk("R3 read frames", nfr, 1);
    chk("R3 read op", fb[0][0], 8'h03);
    chk("R3 read a2", fb[0][1], 8'h12);
    chk("R3 read a1", fb[0][2], 8'h34);
    chk("R3 read a0", fb[0][3], 8'h56);
    chk("R6 read frame bytes", flen[0], 8);
    chk("R6 read count", rxn, 4);
    for (int i = 0; i < 4; i++) chk("R6 read data", rxb[i], 8'h56 + i);
    chk("R8 slow phase", fhi[0], 4);
    chk("R9 read err", int'(err_seen), 0);
  endtask

  task automatic t_fast_bp();
    bp = 1'b1;
    run(4'd1, 24'h0000FE, 8'h00, 8'd3);
    bp = 1'b0;
    chk("R3 fast op", fb[0][0], 8'h0B);
    chk("R3 fast dummy", fb[0][4], 8'h00);
    chk("R6 fast frame bytes", flen[0], 8);
    chk("R7 stalled count", rxn, 3);
    chk("R7 stalled b0", rxb[0], 8'hFE);
    chk("R7 stalled b1", rxb[1], 8'hFF);
    chk("R7 stalled b2", rxb[2], 8'h00);
    chk("R8 fast phase", fhi[0], 2);
  endtask

  task automatic t_prog();
    busy_left = 2;
    run(4'd5, 24'hABCDEF, 8'h3C, 8'd0);
    chk("R4 prog frames", nfr, 5);
    chk("R4 wen alone", flen[0], 1);
    chk("R4 wen code", fb[0][0], 8'h06);
    chk("R3 prog op", fb[1][0], 8'h02);
    chk("R3 prog a0", fb[1][3], 8'hEF);
    chk("R3 prog data", fb[1][4], 8'h3C);
    chk("R9 poll code", fb[4][0], 8'h05);
    chk("R9 poll len", flen[4], 2);
    chk("R9 prog err", int'(err_seen), 0);
    chk("R8 prog phase", fhi[1], 2);
    for (int i = 1; i < 5; i++) chk("R11 gap", int'(fgap[i] >= CS_GAP), 1);
  endtask

  task automatic t_sector();
    busy_left = 0;
    run(4'd2, 24'h00F000, 8'h00, 8'd0);
    chk("R9 sector frames", nfr, 3);
    chk("R3 sector op", fb[1][0], 8'h20);
    chk("R3 sector a1", fb[1][2], 8'hF0);
    chk("R9 sector err", int'(err_seen), 0);
  endtask

  task automatic t_chip_timeout();
    busy_left = 100;
    run(4'd4, 24'h000000, 8'h00, 8'd0);
    chk("R10 frames", nfr, 2 + POLL_LIMIT);
    chk("R3 chip op", fb[1][0], 8'h60);
    chk("R3 chip len", flen[1], 1);
    chk("R10 err", int'(err_seen), 1);
    repeat (100) @(negedge clk);
    chk("R10 no more frames", nfr, 2 + POLL_LIMIT);
    busy_left = 0;
  endtask

  task automatic t_block_busy_cmd();
    busy_left = 1;
    issue(4'd3, 24'h010000, 8'h00, 8'd0);
    repeat (20) @(negedge clk);
    chk("R12 ready low", int'(cmd_ready), 0);
    cmd_valid = 1'b1; cmd_op = 4'd0; cmd_len = 8'd2;
    repeat (10) @(negedge clk);
    cmd_valid = 1'b0;
    wait_done();
    repeat (200) @(negedge clk);
    chk("R12 frames", nfr, 4);
    chk("R3 block op", fb[1][0], 8'hD8);
    chk("R3 block a2", fb[1][1], 8'h01);
    chk("R12 no stream", rxn, 0);
  endtask

  task automatic t_wstat();
    run(4'd8, 24'h0, 8'hA5, 8'd0);
    chk("R5 frames", nfr, 2);
    chk("R5 enable", fb[0][0], 8'h50);
    chk("R5 enable len", flen[0], 1);
    chk("R5 write op", fb[1][0], 8'h01);
    chk("R5 write data", fb[1][1], 8'hA5);
    chk("R5 write len", flen[1], 2);
  endtask

  task automatic t_rstat_rid();
    run(4'd6, 24'h0, 8'h00, 8'd0);
    chk("R6 status frame", fb[0][0], 8'h05);
    chk("R6 status len", flen[0], 2);
    chk("R6 status count", rxn, 1);
    chk("R6 status value", rxb[0], 8'h1C);
    run(4'd7, 24'h0, 8'h00, 8'd0);
    chk("R6 id op", fb[0][0], 8'h9F);
    chk("R6 id len", flen[0], 4);
    chk("R6 id count", rxn, 3);
    chk("R6 id b0", rxb[0], 8'hEF);
    chk("R6 id b1", rxb[1], 8'h40);
    chk("R6 id b2", rxb[2], 8'h17);
  endtask

  task automatic t_bad_op();
    run(4'd11, 24'h0, 8'h00, 8'd0);
    chk("R13 done", int'(done_seen), 1);
    chk("R13 err", int'(err_seen), 1);
    chk("R13 no frame", nfr, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read();
    t_fast_bp();
    t_prog();
    t_sector();
    t_chip_timeout();
    t_block_busy_cmd();
    t_wstat();
    t_rstat_rid();
    t_bad_op();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule